// File: doc/BRIEF.md
# Double-Data-Rate Word Serializer with Forwarded Clock

This block turns parallel words into one serial line that carries two bits in every period of the fast clock. Each word is split by bit index. The even bits go into one shift register and the odd bits into another. Each shift register feeds a one-bit holding register. A two-input selector, steered by the level of the fast clock, passes the even holding register while the clock is high and the odd one while the clock is low.

A second selector of the same structure has its inputs tied to constant one and constant zero. It produces a forwarded clock whose edges pass through the same kind of path as the data, so that one forwarded clock period spans two data bits. Both the data line and the forwarded clock also drive an inverted copy, which gives a true and complement pair for a differential output stage.

A new word is taken every `WORD_W/2` fast-clock cycles. The block raises a one-cycle acknowledge in the cycle in which it takes a word. If no word is offered at that moment, the next frame goes out as all zeros while the forwarded clock keeps running.

Top module: `ddr_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its word-slot counter, both shift registers and both holding registers. From then on `ser_p_o` is 0 and `word_ack_o` is 0.
- R2: `word_ack_o` is high only in the last cycle of each frame, and only when `word_valid_i` is high. Counting rising edges after the first edge with `rst_n` high as edge 1, 2, 3 and so on, the last cycles of the frames are the cycles just before edges 4, 8, 12 and so on. No two acknowledges are adjacent.
- R3: Bits go out lowest index first. In the k-th cycle of a frame (k = 0..WORD_W/2-1), word bit 2k appears while the clock is high and word bit 2k+1 while the clock is low.
- R4: A word taken at a frame-boundary edge begins to appear in the cycle that starts at the next rising edge. For a word taken at edge L, this is the cycle that follows edge L+1.
- R5: If `word_valid_i` is low in the last cycle of a frame, the whole next frame is sent as zeros.
- R6: `word_i` and `word_valid_i` have no effect in any cycle other than the last cycle of a frame.
- R7: `fclk_p_o` is high while the fast clock is high and low while it is low. The output data bit therefore changes on both edges of the forwarded clock.
- R8: `ser_n_o` is always the inverse of `ser_p_o`, and `fclk_n_o` is always the inverse of `fclk_p_o`.
- R9: When a word is offered at every frame boundary, the frames follow one another with no idle bit between them.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock; its level also selects the output half-bit |
| rst_n | input | 1 | Synchronous active-low reset |
| word_i | input | WORD_W | Parallel word offered for the next frame |
| word_valid_i | input | 1 | Marks `word_i` as present |
| word_ack_o | output | 1 | Pulses in the cycle in which the word is taken |
| ser_p_o | output | 1 | Serial data, true polarity |
| ser_n_o | output | 1 | Serial data, complement |
| fclk_p_o | output | 1 | Forwarded clock, true polarity |
| fclk_n_o | output | 1 | Forwarded clock, complement |

## Verification
The bench samples the line once in each half of every cycle. A swapped lane or an off-by-one load edge therefore shows up as bits in the wrong half, or as a word that is shifted by a cycle. It offers junk words with the valid flag set in cycles between frame boundaries. A block that sampled its input outside the boundary would emit those words or acknowledge them. The bench also leaves some frame boundaries without a word. There it expects a zero frame, which catches a design that repeats stale bits or fills the shift registers from the wrong end. Edge patterns such as all ones, a single low or high bit, and alternating bits expose a broken shift order and bits left over from the previous word.

// File: rtl/ddrser_pkg.sv
// Shared constants for the double-data-rate serializer.
// Assumes exactly two lanes: one for each half of the fast clock.
package ddrser_pkg;
    localparam int DDR_LANES = 2;   // bits emitted per fast-clock period
    localparam int LANE_HI   = 0;   // lane driven out while clk is high (even bits)
    localparam int LANE_LO   = 1;   // lane driven out while clk is low (odd bits)
endpackage

// File: rtl/ddrser_loader.sv
// Frame timer: counts fast-clock cycles within one word frame and marks the
// last cycle, in which the next word is taken.
// Assumes SLOTS >= 2 so that an acknowledge can never repeat in the next cycle.
module ddrser_loader #(
    parameter int SLOTS = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic valid_i,
    output logic load_o,
    output logic ack_o
);
    localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    logic [CW-1:0] slot_q;

    // Advance the slot counter and wrap it at the end of each frame.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)             slot_q <= '0;
        else if (slot_q == LAST) slot_q <= '0;
        else                     slot_q <= slot_q + 1'b1;
    end

    // Decode the last slot and the acknowledge for the word taken there.
    always_comb begin
        load_o = (slot_q == LAST);
        ack_o  = load_o && valid_i;
    end

    // R2: there is never an acknowledge without an offered word.
    a_r2_ack_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> valid_i);
    // R2: acknowledges never fall in back-to-back cycles.
    a_r2_ack_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);
endmodule

// File: rtl/ddrser_lane.sv
// One half-bit lane: a shift register, loaded in parallel, that shifts toward
// index 0 and fills with zeros, followed by a single holding register.
// Assumes the load strobe comes once per SLOTS cycles.
module ddrser_lane #(
    parameter int SLOTS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [SLOTS-1:0] bits_i,
    output logic             held_o,
    output logic             empty_o
);
    logic [SLOTS-1:0] sh_q;
    logic             hold_q;

    // Load a new set of lane bits, or shift one step toward the head.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     sh_q <= '0;
        else if (load_i) sh_q <= bits_i;
        else             sh_q <= {1'b0, sh_q[SLOTS-1:1]};
    end

    // Retime the head bit so that the selector sees a stable value for a full cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) hold_q <= 1'b0;
        else         hold_q <= sh_q[0];
    end

    // Drive the held bit out and flag an all-zero shift register.
    always_comb begin
        held_o  = hold_q;
        empty_o = (sh_q == '0);
    end

    // R6: a cycle without a load only shifts, so a zero enters at the top.
    a_r6_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> (sh_q[SLOTS-1] == 1'b0));
endmodule

// File: rtl/ddrser_phase_mux.sv
// Two-input selector steered by a clock level: passes hi_i while sel_i is
// high and lo_i while it is low. The data path and the forwarded-clock path
// use the same structure so that both see matched delays.
module ddrser_phase_mux (
    input  logic sel_i,
    input  logic hi_i,
    input  logic lo_i,
    output logic out_p_o,
    output logic out_n_o
);
    // Pick the half-bit and form the complement pair.
    always_comb begin
        out_p_o = sel_i ? hi_i : lo_i;
        out_n_o = ~out_p_o;
    end
endmodule

// File: rtl/ddr_serializer.sv
// Top of the double-data-rate serializer. It splits each WORD_W-bit word into
// even and odd lanes, sends two bits per fast-clock period and forwards a
// clock through a matched selector.
// Assumes WORD_W is even. The word rate is clk / (WORD_W/2).
module ddr_serializer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              word_ack_o,
    output logic              ser_p_o,
    output logic              ser_n_o,
    output logic              fclk_p_o,
    output logic              fclk_n_o
);
    import ddrser_pkg::*;

    localparam int SLOTS = WORD_W / DDR_LANES;

    logic                 load;
    logic [WORD_W-1:0]    word_in;
    logic [DDR_LANES-1:0] held;
    logic [DDR_LANES-1:0] empty;

    ddrser_loader #(.SLOTS(SLOTS)) u_loader (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .valid_i (word_valid_i),
        .load_o  (load),
        .ack_o   (word_ack_o)
    );

    // Replace a missing word with zeros so that an idle frame is sent as all zeros.
    always_comb word_in = word_valid_i ? word_i : '0;

    for (genvar g = 0; g < DDR_LANES; g++) begin : g_lane
        logic [SLOTS-1:0] lane_bits;
        // Gather every DDR_LANES-th bit, starting at bit g, into this lane.
        for (genvar k = 0; k < SLOTS; k++) begin : g_bit
            assign lane_bits[k] = word_in[k*DDR_LANES + g];
        end
        ddrser_lane #(.SLOTS(SLOTS)) u_lane (
            .clk_i   (clk),
            .rst_ni  (rst_n),
            .load_i  (load),
            .bits_i  (lane_bits),
            .held_o  (held[g]),
            .empty_o (empty[g])
        );
    end

    ddrser_phase_mux u_data_mux (
        .sel_i   (clk),
        .hi_i    (held[LANE_HI]),
        .lo_i    (held[LANE_LO]),
        .out_p_o (ser_p_o),
        .out_n_o (ser_n_o)
    );

    ddrser_phase_mux u_clk_mux (
        .sel_i   (clk),
        .hi_i    (1'b1),
        .lo_i    (1'b0),
        .out_p_o (fclk_p_o),
        .out_n_o (fclk_n_o)
    );

    // R5: a frame boundary without a word leaves both lanes empty.
    a_r5_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !word_valid_i) |=> (&empty));
endmodule

// File: tb/test_ddr_serializer.sv
// Bench for ddr_serializer: directed corner words followed by seeded random words.
// Samples the outputs in both clock phases and checks them against a frame model.
module test_ddr_serializer;
    localparam int W       = 8;
    localparam int SL      = W / 2;
    localparam int NCYC    = 600;
    localparam int NFRAMES = NCYC / SL + 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_i = '0;
    logic         word_valid_i = 1'b0;
    logic         word_ack_o, ser_p_o, ser_n_o, fclk_p_o, fclk_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] frames [NFRAMES];
    logic         exp_ack;

    always #5 clk = ~clk;

    ddr_serializer #(.WORD_W(W)) i_ddr_serializer (
        .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_valid_i(word_valid_i),
        .word_ack_o(word_ack_o), .ser_p_o(ser_p_o), .ser_n_o(ser_n_o),
        .fclk_p_o(fclk_p_o), .fclk_n_o(fclk_n_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected serial bit in cycle c (cycle after edge c) for the given phase (0 = high).
    function automatic logic exp_bit(input int c, input int phase);
        int l;
        if (c <= SL) return 1'b0;
        l = SL * ((c - 1) / SL);
        return frames[l / SL][2 * ((c - 1) % SL) + phase];
    endfunction

    function automatic logic [W-1:0] directed(input int f);
        case (f)
            1: return 8'hFF;
            2: return 8'h00;
            3: return 8'hAA;
            4: return 8'h55;
            5: return 8'h01;
            6: return 8'h80;
            default: return 8'hFE;
        endcase
    endfunction

    // Drive the inputs for edge e and record the frame it would load.
    task automatic drive_for_edge(input int e);
        logic [W-1:0] w;
        logic v;
        w = W'($urandom);
        v = ($urandom % 4) != 0;
        if (e % SL == 0) begin
            if (e / SL <= 7) begin
                w = directed(e / SL);
                v = (e / SL != 2) && (e / SL != 7);   // R5: two idle boundaries
            end
            frames[e / SL] = v ? w : '0;
            exp_ack = v;
        end else begin
            v = 1'b1;                                 // R6: junk offered off-boundary
            exp_ack = 1'b0;
        end
        word_i = w;
        word_valid_i = v;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NFRAMES; i++) frames[i] = '0;
        word_valid_i = 1'b1;
        word_i = 8'hC3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 reset data", ser_p_o, 1'b0);
        check("R1 reset ack", word_ack_o, 1'b0);
        check("R8 reset complement", ser_n_o, 1'b1);
        rst_n = 1'b1;
        drive_for_edge(1);
        #1 check("R2 ack after release", word_ack_o, exp_ack);
        for (int c = 1; c <= NCYC; c++) begin
            @(posedge clk);
            #2;
            check("R3 R4 R9 high-phase bit", ser_p_o, exp_bit(c, 0));
            check("R8 data complement hi", ser_n_o, ~exp_bit(c, 0));
            check("R7 fclk high", fclk_p_o, 1'b1);
            check("R8 fclk complement hi", fclk_n_o, 1'b0);
            @(negedge clk);
            drive_for_edge(c + 1);
            #1;
            check("R3 R5 R6 low-phase bit", ser_p_o, exp_bit(c, 1));
            check("R8 data complement lo", ser_n_o, ~exp_bit(c, 1));
            check("R7 fclk low", fclk_p_o, 1'b0);
            check("R8 fclk complement lo", fclk_n_o, 1'b1);
            check("R2 R6 ack", word_ack_o, exp_ack);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * NCYC + 2000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule